// File: doc/BRIEF.md
# Auxiliary-Channel Request Message Buffer

This block holds one auxiliary-channel request while software builds it: a three-byte header with command and address, one length byte, and up to sixteen payload bytes. Software writes these into a bank of twenty byte registers through a simple write port. It then writes the total message size to a separate launch address. That write starts the transfer. The block then hands the stored bytes one at a time to a downstream channel encoder over a valid/ready byte stream and flags the final byte.

Software reads a ready output and waits for it to be high before it loads a new request. Ready drops on an accepted launch and comes back only after the encoder has taken the final byte. While ready is low, the bank is locked: byte writes are dropped. A launch is refused, and a sticky error flag is raised, when the size falls outside the legal range of 4 to 20 or when a transfer is already in progress.

Top module: `aux_req_buffer`

## Requirements
- R1: During and after reset, `tx_ready` is 1, `out_valid` is 0, `len_err` is 0, and every byte register reads back as 0 when transmitted.
- R2: A write to address 20 with a value from 4 to 20 while `tx_ready` is 1 starts a transfer. On the next clock, `tx_ready` is 0 and `out_valid` is 1.
- R3: A started transfer of size N emits exactly N bytes, taken from byte registers 0 to N-1 in ascending address order.
- R4: `out_last` is 1 on byte N-1 of the transfer and 0 on every other byte.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold their values, and `out_valid` stays 1.
- R6: `tx_ready` returns to 1 on the clock after the final byte is accepted (`out_valid`, `out_ready` and `out_last` all 1). It stays 0 until then, and `out_valid` is never 1 while `tx_ready` is 1.
- R7: A write to address 20 with a value below 4 or above 20 starts nothing. `tx_ready` stays 1, `out_valid` stays 0, and `len_err` becomes 1.
- R8: A write to address 20 while `tx_ready` is 0 leaves the running transfer's size and bytes unchanged and sets `len_err`.
- R9: A write to byte addresses 0 to 19 while `tx_ready` is 0 is dropped. The next transfer emits the value stored before that write.
- R10: Once set, `len_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address: 0 to 19 are byte registers, 20 is the launch size |
| wr_data | input | 8 | Write data |
| tx_ready | output | 1 | High when a new request may be loaded and launched |
| len_err | output | 1 | Sticky flag for a refused launch |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Marks the final byte of the request |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
The transfer path is driven with directed sizes at both limits (4 and 20) and with random sizes, payloads and downstream acceptance rates. These separate off-by-one errors in the byte count and the last marker from ordering faults, and a stalled stream exposes any byte that changes while held. Launch sizes just outside the range (3 and 21) check the bounds comparison. Writes injected in mid-transfer, one to the launch address and one to a byte register, show whether the lock on the running request is effective: the current stream must finish unchanged, and a relaunch must replay the old byte.

// File: rtl/aux_req_pkg.sv
package aux_req_pkg;

    localparam int HDR_BYTES      = 3;
    localparam int LEN_FIELD_BYTES = 1;
    localparam int MAX_DATA_BYTES = 16;
    localparam int MIN_MSG_BYTES  = HDR_BYTES + LEN_FIELD_BYTES;
    localparam int MAX_MSG_BYTES  = MIN_MSG_BYTES + MAX_DATA_BYTES;
    localparam int BYTE_W         = 8;
    localparam int ADDR_W         = $clog2(MAX_MSG_BYTES + 1);
    localparam int IDX_W          = $clog2(MAX_MSG_BYTES + 1);

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic              last;
        logic [BYTE_W-1:0] data;
    } out_beat_t;

    typedef struct packed {
        logic             go;
        logic [IDX_W-1:0] size;
    } launch_t;

    function automatic logic size_legal(input logic [BYTE_W-1:0] sz);
        return (int'(sz) >= MIN_MSG_BYTES) && (int'(sz) <= MAX_MSG_BYTES);
    endfunction

endpackage

// File: rtl/aux_req_bank.sv
module aux_req_bank
    import aux_req_pkg::*;
#(
    parameter int DEPTH  = MAX_MSG_BYTES,
    parameter int AW     = ADDR_W,
    parameter int DW     = BYTE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic                     unlocked,
    output logic [DEPTH-1:0][DW-1:0] bank_q
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_byte
        localparam logic [AW-1:0] MY_ADDR = AW'(i);
        logic hit;
        assign hit = wr_en && unlocked && (wr_addr == MY_ADDR);
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_q[i] <= '0;
            end else if (hit) begin
                bank_q[i] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/aux_req_launch.sv
module aux_req_launch
    import aux_req_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W,
    parameter int LAUNCH_ADDR = MAX_MSG_BYTES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          xfer_done,
    output launch_t       launch,
    output logic          ready_q,
    output logic          err_q
);

    localparam logic [AW-1:0] LADDR = AW'(LAUNCH_ADDR);

    logic launch_hit;
    logic legal;
    logic refuse;

    assign launch_hit  = wr_en && (wr_addr == LADDR);
    assign legal       = size_legal(wr_data);
    assign launch.go   = launch_hit && ready_q && legal;
    assign launch.size = IDX_W'(wr_data);
    assign refuse      = launch_hit && !(ready_q && legal);

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b1;
            err_q   <= 1'b0;
        end else begin
            if (launch.go) begin
                ready_q <= 1'b0;
            end else if (xfer_done) begin
                ready_q <= 1'b1;
            end
            if (refuse) begin
                err_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/aux_req_serializer.sv
module aux_req_serializer
    import aux_req_pkg::*;
#(
    parameter int DEPTH = MAX_MSG_BYTES,
    parameter int DW    = BYTE_W,
    parameter int IW    = IDX_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  launch_t                  launch,
    input  logic [DEPTH-1:0][DW-1:0] bank_q,
    input  logic                     out_ready,
    output logic                     out_valid,
    output out_beat_t                beat,
    output logic                     xfer_done
);

    tx_state_e       state_q;
    logic [IW-1:0]   idx_q;
    logic [IW-1:0]   total_q;
    logic            at_end;
    logic            take;

    assign out_valid = (state_q == ST_SEND);
    assign at_end    = (idx_q == total_q - IW'(1));
    assign take      = out_valid && out_ready;
    assign xfer_done = take && at_end;

    always_comb begin
        beat.last = out_valid && at_end;
        beat.data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (idx_q == IW'(i)) begin
                beat.data = bank_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            total_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (launch.go) begin
                        state_q <= ST_SEND;
                        idx_q   <= '0;
                        total_q <= launch.size;
                    end
                end
                ST_SEND: begin
                    if (take) begin
                        if (at_end) begin
                            state_q <= ST_IDLE;
                            idx_q   <= '0;
                        end else begin
                            idx_q <= idx_q + IW'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/aux_req_buffer.sv
module aux_req_buffer
    import aux_req_pkg::*;
#(
    parameter int DEPTH = MAX_MSG_BYTES,
    parameter int AW    = ADDR_W,
    parameter int DW    = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          tx_ready,
    output logic          len_err,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_last,
    input  logic          out_ready
);

    logic [DEPTH-1:0][DW-1:0] bank_q;
    launch_t                  launch;
    out_beat_t                beat;
    logic                     xfer_done;

    aux_req_bank #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .unlocked (tx_ready),
        .bank_q   (bank_q)
    );

    aux_req_launch #(.AW(AW), .DW(DW), .LAUNCH_ADDR(DEPTH)) u_launch (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .xfer_done (xfer_done),
        .launch    (launch),
        .ready_q   (tx_ready),
        .err_q     (len_err)
    );

    aux_req_serializer #(.DEPTH(DEPTH), .DW(DW), .IW(IDX_W)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .bank_q    (bank_q),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .beat      (beat),
        .xfer_done (xfer_done)
    );

    assign out_data = beat.data;
    assign out_last = beat.last;

endmodule

// File: rtl/aux_req_buffer_chk.sv
module aux_req_buffer_chk
    import aux_req_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W,
    parameter int LAUNCH_ADDR = MAX_MSG_BYTES
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          tx_ready,
    input logic          len_err,
    input logic          out_valid,
    input logic [DW-1:0] out_data,
    input logic          out_last,
    input logic          out_ready
);

    logic launch_wr;
    logic in_range;
    assign launch_wr = wr_en && (wr_addr == AW'(LAUNCH_ADDR));
    assign in_range  = (int'(wr_data) >= MIN_MSG_BYTES) && (int'(wr_data) <= MAX_MSG_BYTES);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (tx_ready && !out_valid && !len_err)) else $error("reset state"); // R1

    AST_LAUNCH_START: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && launch_wr && in_range) |=> (out_valid && !tx_ready)) else $error("launch"); // R2

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))) else $error("hold"); // R5

    AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> tx_ready) else $error("ready return"); // R6

    AST_READY_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> !out_valid) else $error("ready with valid"); // R6

    AST_BAD_SIZE: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && launch_wr && !in_range) |=> (tx_ready && !out_valid && len_err)) else $error("bad size"); // R7

    AST_BUSY_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (!tx_ready && launch_wr) |=> len_err) else $error("busy launch"); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        len_err |=> len_err) else $error("sticky"); // R10

endmodule

bind aux_req_buffer aux_req_buffer_chk #(.AW(AW), .DW(DW), .LAUNCH_ADDR(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tx_ready  (tx_ready),
    .len_err   (len_err),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_ready (out_ready)
);

// File: tb/aux_req_buffer_test.sv
module aux_req_buffer_test;

    localparam int NBYTES = 20;
    localparam logic [4:0] LEN_ADDR = 5'd20;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [4:0] wr_addr;
    logic [7:0] wr_data;
    logic       tx_ready;
    logic       len_err;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_last;
    logic       out_ready;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_buf [NBYTES];

    always #4 clk = ~clk;

    aux_req_buffer uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tx_ready(tx_ready), .len_err(len_err), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit legal(input int sz);
        return sz >= 4 && sz <= NBYTES;
    endfunction

    task automatic do_reset();
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; out_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NBYTES; i++) exp_buf[i] = 8'h00;
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = 8'($urandom);
            exp_buf[i] = v;
            reg_write(5'(i), v);
        end
    endtask

    task automatic run_msg(input int len, input int inj_step, input logic [4:0] inj_addr,
                           input logic [7:0] inj_data, input int pct);
        int got = 0;
        int step = 0;
        bit fin = 0;
        bit stalled = 0;
        logic [7:0] held = '0;
        reg_write(LEN_ADDR, 8'(len));
        chk(tx_ready == 1'b0, "R2 ready low after launch", int'(tx_ready), 0);
        chk(out_valid == 1'b1, "R2 valid after launch", int'(out_valid), 1);
        while (!fin && step < 2000) begin
            if (stalled) begin
                chk(out_valid && out_data == held, "R5 held byte", int'(out_data), int'(held));
            end
            out_ready = (($urandom % 100) < 32'(pct));
            if (step == inj_step) begin
                wr_en = 1'b1; wr_addr = inj_addr; wr_data = inj_data;
            end else begin
                wr_en = 1'b0;
            end
            stalled = out_valid && !out_ready;
            held = out_data;
            if (out_valid && out_ready) begin
                chk(out_data == exp_buf[got], "R3 byte order", int'(out_data), int'(exp_buf[got]));
                chk(out_last == (got == len - 1), "R4 last marker", int'(out_last), int'(got == len - 1));
                if (out_last) fin = 1;
                got++;
            end
            @(negedge clk);
            step++;
        end
        wr_en = 1'b0; out_ready = 1'b0;
        chk(got == len, "R3 byte count", got, len);
        chk(tx_ready == 1'b1, "R6 ready back", int'(tx_ready), 1);
        chk(out_valid == 1'b0, "R6 valid idle", int'(out_valid), 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd7411));
        do_reset();
        chk(tx_ready == 1'b1, "R1 ready", int'(tx_ready), 1);
        chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        chk(len_err == 1'b0, "R1 err", int'(len_err), 0);
        run_msg(4, -1, '0, '0, 100); // R1 cleared bytes are zero

        load_bytes(NBYTES);
        run_msg(20, -1, '0, '0, 100);
        run_msg(4, -1, '0, '0, 40);
        chk(len_err == 1'b0, "R2 no error on legal sizes", int'(len_err), 0);

        reg_write(LEN_ADDR, 8'd3);
        chk(tx_ready && !out_valid, "R7 size 3 ignored", int'(out_valid), 0);
        chk(len_err == 1'b1, "R7 size 3 error", int'(len_err), 1);
        repeat (5) @(negedge clk);
        chk(len_err == 1'b1, "R10 err sticky", int'(len_err), 1);
        run_msg(6, -1, '0, '0, 100);
        chk(len_err == 1'b1, "R10 err survives transfer", int'(len_err), 1);

        do_reset();
        chk(len_err == 1'b0, "R1 err cleared by reset", int'(len_err), 0);
        reg_write(LEN_ADDR, 8'd21);
        chk(tx_ready && !out_valid, "R7 size 21 ignored", int'(out_valid), 0);
        chk(len_err == 1'b1, "R7 size 21 error", int'(len_err), 1);

        do_reset();
        load_bytes(NBYTES);
        run_msg(10, 1, LEN_ADDR, 8'd5, 60);
        chk(len_err == 1'b1, "R8 busy launch error", int'(len_err), 1);

        do_reset();
        load_bytes(8);
        run_msg(8, 1, 5'd0, ~exp_buf[0], 50);
        run_msg(8, -1, '0, '0, 100); // R9 old byte replayed

        for (int n = 0; n < 25; n++) begin
            int len;
            len = 4 + int'($urandom % 17);
            if (!legal(len)) len = 4;
            load_bytes(len);
            run_msg(len, -1, '0, '0, 30 + int'($urandom % 71));
        end
        finish_run();
    end

endmodule